// File: doc/BRIEF.md
# Programmable On/Off Clock Divider

This block produces a slower functional clock for a camera interface from a fast source clock (nominally 240 MHz). The high phase and the low phase of the output are set separately, each as a whole number of source cycles from 1 to 8. The output period can therefore run from 2 to 16 source cycles, which is 120 MHz down to 15 MHz, and the duty cycle is programmable as well.

Software writes a 32-bit configuration word. Readback shows the written value at once. The divider copies that value into its working settings only when a low phase ends. The period in progress always finishes with the settings it started with, so no short or truncated pulse appears on the output.

A one-cycle rise pulse marks every low-to-high transition of the divided clock. Downstream logic in the source domain can use it as a clock-enable.

Top module: `onoff_clk_div`

## Requirements
- R1: The high length sits in configuration bits 2:0 and the low length in bits 10:8. Each 3-bit field with value v selects v+1 source cycles (000 gives 1 cycle, 111 gives 8 cycles).
- R2: From the cycle after a write, `cfgRdata` returns the written word with every bit outside 2:0 and 10:8 forced to zero. Writes to those other bits have no effect.
- R3: While `rstN` is low, `clkOut` and `risePulse` are low and `cfgRdata` is zero. The first clock edge after release starts a high phase, and the output then divides by 2 with 50% duty.
- R4: `clkOut` repeats a high phase of ON+1 cycles followed by a low phase of OFF+1 cycles, with no gap between periods.
- R5: A write takes effect only at the end of the current low phase. A period already under way completes with the previous lengths.
- R6: `risePulse` is high for exactly one cycle: the first high cycle of each period. It is low at all other times.
- R7: No phase of `clkOut` lasts longer than 8 source cycles, whatever value is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkSrc | input | 1 | Fast source clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgWdata | input | 32 | Configuration write data |
| cfgRdata | output | 32 | Configuration readback |
| clkOut | output | 1 | Divided clock, driven from a register |
| risePulse | output | 1 | One-cycle pulse in the first high cycle of each period |

## Verification
On every cycle, the assertions check four things: the zero readback of the unused bits, the masked echo of each write, the pairing between `risePulse` and a low-to-high step of `clkOut`, and the 8-cycle limit on each phase. Two properties are sequence-dependent and are shown only by the bench's scenarios. One is the exact length of each phase for a given setting. The other is the deferral of a new setting until the current low phase ends. The bench shows both by tracking a cycle model through random writes that arrive at arbitrary points of a period, and by measuring phases directly.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  // Strobes issued by the phase control to the datapath.
  typedef struct packed {
    logic cntClr;    // restart the phase counter
    logic loadWork;  // copy configuration into working lengths
    logic goHigh;    // low phase finished, next cycle is high
    logic goLow;     // high phase finished, next cycle is low
  } pcdStrobe_t;
endpackage

// File: rtl/pcd_datapath.sv
module pcd_datapath #(
  parameter int REG_W   = 32,
  parameter int LEN_W   = 3,
  parameter int ON_LSB  = 0,
  parameter int OFF_LSB = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWe,
  input  logic [REG_W-1:0]     cfgWdata,
  input  pcd_pkg::pcdStrobe_t  strobe,
  input  logic                 phaseHigh,
  output logic [REG_W-1:0]     cfgRdata,
  output logic                 phaseEnd
);
  localparam logic [REG_W-1:0] FIELD_ONES = {{(REG_W-LEN_W){1'b0}}, {LEN_W{1'b1}}};
  localparam logic [REG_W-1:0] CFG_MASK   = (FIELD_ONES << ON_LSB) | (FIELD_ONES << OFF_LSB);

  logic [REG_W-1:0] cfgReg;
  logic [LEN_W-1:0] onWork;
  logic [LEN_W-1:0] offWork;
  logic [LEN_W-1:0] phaseCnt;
  logic [LEN_W-1:0] target;

  // Programmed value; only the two length fields are stored.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      cfgReg <= '0;
    else if (cfgWe) cfgReg <= cfgWdata & CFG_MASK;
  end

  // Working lengths, refreshed only at a period boundary.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      onWork  <= '0;
      offWork <= '0;
    end else if (strobe.loadWork) begin
      onWork  <= cfgReg[ON_LSB +: LEN_W];
      offWork <= cfgReg[OFF_LSB +: LEN_W];
    end
  end

  // Cycle count within the current phase.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              phaseCnt <= '0;
    else if (strobe.cntClr) phaseCnt <= '0;
    else                    phaseCnt <= phaseCnt + 1'b1;
  end

  assign target   = phaseHigh ? onWork : offWork;
  assign phaseEnd = (phaseCnt == target);
  assign cfgRdata = cfgReg;
endmodule

// File: rtl/pcd_ctrl.sv
module pcd_ctrl (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 phaseEnd,
  output pcd_pkg::pcdStrobe_t  strobe,
  output logic                 phaseHigh,
  output logic                 risePulse
);
  logic clkReg;
  logic riseReg;

  always_comb begin
    strobe          = '0;
    strobe.cntClr   = phaseEnd;
    strobe.goHigh   = phaseEnd & ~clkReg;
    strobe.loadWork = phaseEnd & ~clkReg;
    strobe.goLow    = phaseEnd & clkReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkReg  <= 1'b0;
      riseReg <= 1'b0;
    end else begin
      if (strobe.goHigh)     clkReg <= 1'b1;
      else if (strobe.goLow) clkReg <= 1'b0;
      riseReg <= strobe.goHigh;
    end
  end

  assign phaseHigh = clkReg;
  assign risePulse = riseReg;
endmodule

// File: rtl/onoff_clk_div.sv
module onoff_clk_div #(
  parameter int REG_W   = 32,
  parameter int LEN_W   = 3,
  parameter int ON_LSB  = 0,
  parameter int OFF_LSB = 8
) (
  input  logic             clkSrc,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [REG_W-1:0] cfgWdata,
  output logic [REG_W-1:0] cfgRdata,
  output logic             clkOut,
  output logic             risePulse
);
  pcd_pkg::pcdStrobe_t strobe;
  logic phaseEnd;
  logic phaseHigh;

  pcd_ctrl u_ctrl (
    .clk       (clkSrc),
    .rstN      (rstN),
    .phaseEnd  (phaseEnd),
    .strobe    (strobe),
    .phaseHigh (phaseHigh),
    .risePulse (risePulse)
  );

  pcd_datapath #(
    .REG_W   (REG_W),
    .LEN_W   (LEN_W),
    .ON_LSB  (ON_LSB),
    .OFF_LSB (OFF_LSB)
  ) u_dp (
    .clk       (clkSrc),
    .rstN      (rstN),
    .cfgWe     (cfgWe),
    .cfgWdata  (cfgWdata),
    .strobe    (strobe),
    .phaseHigh (phaseHigh),
    .cfgRdata  (cfgRdata),
    .phaseEnd  (phaseEnd)
  );

  assign clkOut = phaseHigh;
endmodule

// File: rtl/pcd_checker.sv
module pcd_checker #(
  parameter int REG_W   = 32,
  parameter int LEN_W   = 3,
  parameter int ON_LSB  = 0,
  parameter int OFF_LSB = 8
) (
  input logic             clkSrc,
  input logic             rstN,
  input logic             cfgWe,
  input logic [REG_W-1:0] cfgWdata,
  input logic [REG_W-1:0] cfgRdata,
  input logic             clkOut,
  input logic             risePulse
);
  localparam int MAX_LEN = 1 << LEN_W;
  localparam logic [REG_W-1:0] FIELD_ONES = {{(REG_W-LEN_W){1'b0}}, {LEN_W{1'b1}}};
  localparam logic [REG_W-1:0] KEEP = (FIELD_ONES << ON_LSB) | (FIELD_ONES << OFF_LSB);

  logic [LEN_W+1:0] hiRun;
  logic [LEN_W+1:0] loRun;

  always_ff @(posedge clkSrc or negedge rstN) begin
    if (!rstN) begin
      hiRun <= '0;
      loRun <= '0;
    end else begin
      hiRun <= clkOut ? hiRun + 1'b1 : '0;
      loRun <= clkOut ? '0 : loRun + 1'b1;
    end
  end

  p_unused_zero_r2: assert property (@(posedge clkSrc) disable iff (!rstN)
    (cfgRdata & ~KEEP) == '0);

  p_write_echo_r2: assert property (@(posedge clkSrc) disable iff (!rstN)
    cfgWe |=> cfgRdata == ($past(cfgWdata) & KEEP));

  p_rise_on_edge_r6: assert property (@(posedge clkSrc) disable iff (!rstN)
    risePulse |-> (clkOut && !$past(clkOut)));

  p_edge_has_rise_r6: assert property (@(posedge clkSrc) disable iff (!rstN)
    $rose(clkOut) |-> risePulse);

  p_high_bound_r7: assert property (@(posedge clkSrc) disable iff (!rstN)
    int'(hiRun) <= MAX_LEN);

  p_low_bound_r7: assert property (@(posedge clkSrc) disable iff (!rstN)
    int'(loRun) <= MAX_LEN);
endmodule

bind onoff_clk_div pcd_checker #(
  .REG_W   (REG_W),
  .LEN_W   (LEN_W),
  .ON_LSB  (ON_LSB),
  .OFF_LSB (OFF_LSB)
) u_chk (
  .clkSrc    (clkSrc),
  .rstN      (rstN),
  .cfgWe     (cfgWe),
  .cfgWdata  (cfgWdata),
  .cfgRdata  (cfgRdata),
  .clkOut    (clkOut),
  .risePulse (risePulse)
);

// File: tb/sim_onoff_clk_div.sv
module sim_onoff_clk_div;
  logic        clkSrc = 1'b0;
  logic        rstN   = 1'b0;
  logic        cfgWe  = 1'b0;
  logic [31:0] cfgWdata = '0;
  logic [31:0] cfgRdata;
  logic        clkOut;
  logic        risePulse;

  int checks = 0;
  int fails  = 0;
  bit checkOn = 1'b0;

  // Bench model state
  int          mCnt  = 0;
  int          mOn   = 0;
  int          mOff  = 0;
  bit          mHigh = 1'b0;
  bit          mRise = 1'b0;
  logic [31:0] mCfg  = '0;

  onoff_clk_div u0 (
    .clkSrc    (clkSrc),
    .rstN      (rstN),
    .cfgWe     (cfgWe),
    .cfgWdata  (cfgWdata),
    .cfgRdata  (cfgRdata),
    .clkOut    (clkOut),
    .risePulse (risePulse)
  );

  always #4 clkSrc = ~clkSrc;

  // R1/R2: only bits 2:0 and 10:8 are kept.
  function automatic logic [31:0] keepBits(input logic [31:0] v);
    return v & 32'h0000_0707;
  endfunction

  function automatic int onLenOf(input logic [31:0] v);
    return int'(v[2:0]) + 1;
  endfunction

  function automatic int offLenOf(input logic [31:0] v);
    return int'(v[10:8]) + 1;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  // Cycle model built from R3..R6; lengths counted as v+1 per R1.
  always @(posedge clkSrc) begin
    if (!rstN) begin
      mCnt = 0; mOn = 1; mOff = 1; mHigh = 0; mRise = 0; mCfg = '0;
    end else begin
      mRise = 0;
      mCnt++;
      if (mHigh && mCnt >= mOn) begin
        mHigh = 0; mCnt = 0;
      end else if (!mHigh && mCnt >= mOff) begin
        mOn = onLenOf(mCfg); mOff = offLenOf(mCfg);   // R5
        mHigh = 1; mRise = 1; mCnt = 0;
      end
      if (cfgWe) mCfg = keepBits(cfgWdata);
    end
  end

  initial begin
    mOn = 1; mOff = 1;
  end

  always @(negedge clkSrc) begin
    if (checkOn) begin
      check("R4", "clkOut", int'(clkOut), int'(mHigh));
      check("R6", "risePulse", int'(risePulse), int'(mRise));
      check("R2", "cfgRdata", int'(cfgRdata), int'(mCfg));
    end
  end

  task automatic writeCfg(input logic [31:0] v);
    @(negedge clkSrc);
    cfgWe = 1'b1; cfgWdata = v;
    @(negedge clkSrc);
    cfgWe = 1'b0; cfgWdata = '0;
  endtask

  task automatic waitRise();
    do @(negedge clkSrc); while (!risePulse);
  endtask

  // Measure one full period starting at a rise (R1, R4).
  task automatic measure(input int expHi, input int expLo);
    int hi = 0;
    int lo = 0;
    waitRise();
    while (clkOut) begin hi++; @(negedge clkSrc); end
    while (!clkOut) begin lo++; @(negedge clkSrc); end
    check("R1", "high length", hi, expHi);
    check("R1", "low length", lo, expLo);
  endtask

  initial begin
    repeat (150000) @(posedge clkSrc);
    fails++; checks++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd17));
    // R3: reset state
    repeat (3) @(negedge clkSrc);
    check("R3", "clkOut in reset", int'(clkOut), 0);
    check("R3", "risePulse in reset", int'(risePulse), 0);
    check("R3", "cfgRdata in reset", int'(cfgRdata), 0);
    rstN = 1'b1;
    checkOn = 1'b1;
    measure(1, 1);                       // R3: divide-by-2 after reset

    writeCfg(32'hFFFF_FFFF);             // R2: unused bits ignored
    check("R2", "masked readback", int'(cfgRdata), 32'h0707);
    waitRise();
    measure(8, 8);                       // R7: maximum lengths
    writeCfg(32'h0000_0502);
    waitRise();
    measure(3, 6);                       // R1
    writeCfg(32'h0000_0007);
    waitRise();
    measure(8, 1);                       // R1: asymmetric duty

    // R5: write in the middle of a high phase
    waitRise();
    @(negedge clkSrc);
    cfgWe = 1'b1; cfgWdata = 32'h0000_0300;
    @(negedge clkSrc);
    cfgWe = 1'b0;
    begin
      int hi = 2;
      while (clkOut) begin hi++; @(negedge clkSrc); end
      check("R5", "old high kept", hi, 8);
    end
    measure(1, 4);

    // Random writes at arbitrary points, tracked by the model (R4, R5, R6)
    for (int i = 0; i < 60; i++) begin
      repeat ($urandom_range(0, 30)) @(negedge clkSrc);
      writeCfg($urandom());
    end
    repeat (40) @(negedge clkSrc);

    // R3: reset in mid-run
    rstN = 1'b0;
    checkOn = 1'b0;
    @(negedge clkSrc);
    check("R3", "clkOut mid reset", int'(clkOut), 0);
    check("R3", "cfgRdata mid reset", int'(cfgRdata), 0);
    rstN = 1'b1;
    checkOn = 1'b1;
    measure(1, 1);
    repeat (10) @(negedge clkSrc);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule